// File: doc/BRIEF.md
# Transmit Endpoint Control and Status

This block holds the control/status byte of one USB transmit endpoint and the state that sits behind it. Software reads and writes the byte through a plain register port. Data-packet commits and flushes move a packet counter for a FIFO that holds one or two packets. The protocol engine reports what happened on the bus as one-cycle event pulses. From the register writes and the events, the block produces registered strobes:

- a data-toggle clear,
- a flush of the latest packet,
- a flush of the whole FIFO,
- a DMA abort,
- the endpoint's transmit interrupt.

A mode input selects host or device meaning for two of the bits.

In host mode the block counts failed attempts on bulk and interrupt endpoints. It also runs a frame-based NAK timer on bulk endpoints that halts the endpoint when it expires. In device mode it drives the STALL reply level and records underruns. All strobes and register state change on the clock edge that samples the causing write or event.

Top module: `tx_ep_ctrl`

## Requirements
- R1: After reset `rd_data` reads 0x00 and every output strobe and level is 0.
- R2: Read layout from bit 7 down to bit 0:
  - bit 7: NAK-timeout, reads 0 in device mode.
  - bit 6: toggle-clear, always reads 0.
  - bit 5: stalled.
  - bit 4: setup (host) or send-stall (device).
  - bit 3: flush, always reads 0.
  - bit 2: error (host) or underrun (device).
  - bit 1: FIFO-not-empty, 1 when at least one packet is held. Writes to bit 1 are ignored.
  - bit 0: TX-ready, 1 when the FIFO holds `FIFO_PKTS` packets.
- R3: A write with bit 0 = 1 and bit 3 = 0 commits one packet when the FIFO is not full. When the FIFO is full the write is ignored. With two-packet buffering, bit 0 reads 0 after the first commit.
- R4: `ev_sent` with a non-empty FIFO removes the oldest packet and pulses `tx_irq` for one cycle.
- R5: A write with bit 3 = 1 and bit 0 = 0 on a non-empty FIFO removes the newest packet and pulses `fifo_flush_last` and `tx_irq`. On an empty FIFO the write has no effect.
- R6: A write with bits 3 and 0 both 1 aborts the packet being loaded. It pulses `fifo_flush_last` and `tx_irq` and leaves the packet count unchanged.
- R7: Writing 1 to bit 6 pulses `toggle_clr`. In host mode, writing 1 to bit 4 also pulses `toggle_clr`. `send_setup` follows bit 4 in host mode.
- R8: In host mode with `ep_kind` 2'b10 (bulk) or 2'b11 (interrupt), a third `ev_noack` in a row, with no `ev_sent`, `ev_nak` or `ev_stall` between, does all of the following:
  - sets bit 2,
  - empties the FIFO,
  - pulses `fifo_flush_all` and `tx_irq`.

  For `ep_kind` 2'b00 and 2'b01, `ev_noack` is ignored.
- R9: In host mode `ev_stall` (STALL received) sets bit 5, empties the FIFO and pulses `fifo_flush_all` and `dma_abort`.
- R10: In device mode `stall_reply` follows bit 4. `ev_stall` (STALL sent) sets bit 5, empties the FIFO and pulses `fifo_flush_all` without `dma_abort`.
- R11: In device mode, `ev_in` with an empty FIFO and bit 4 clear sets bit 2. With bit 4 set it does not.
- R12: Bits 7, 5 and 2 are sticky. A write with that bit 0 clears it, and a write with that bit 1 leaves it unchanged.
- R13: In host mode with `ep_kind` 2'b10, `ev_nak` arms the NAK timer and each later `sof_tick` counts one frame. The tick that brings the count to `nak_limit` sets bit 7 and raises `ep_halted`. `ev_sent` or `ev_stall` clears the count. A `nak_limit` of 0 disables the timeout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| host_mode | input | 1 | 1 = host, 0 = device |
| ep_kind | input | 2 | 00 control, 01 isochronous, 10 bulk, 11 interrupt |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Register write value |
| rd_data | output | 8 | Register read value |
| ev_sent | input | 1 | Data packet transmitted and acknowledged |
| ev_noack | input | 1 | Attempt ended with no handshake |
| ev_nak | input | 1 | NAK handshake received |
| ev_stall | input | 1 | STALL received (host) or sent (device) |
| ev_in | input | 1 | IN token seen (device) |
| sof_tick | input | 1 | One-cycle frame strobe |
| nak_limit | input | NAK_W | NAK timeout in frames, 0 = off |
| toggle_clr | output | 1 | Clear the data toggle |
| send_setup | output | 1 | Host: next token is SETUP |
| stall_reply | output | 1 | Device: answer IN with STALL |
| fifo_flush_last | output | 1 | Drop the newest FIFO packet |
| fifo_flush_all | output | 1 | Empty the FIFO |
| tx_irq | output | 1 | Set the endpoint transmit interrupt |
| dma_abort | output | 1 | Stop the DMA request in progress |
| ep_halted | output | 1 | Host: endpoint halted by NAK timeout |

## Verification
The assertions check relations that must hold on every cycle:

- a toggle-clear write is followed by the strobe;
- a whole-FIFO flush leaves the not-empty and ready bits at 0;
- a DMA abort only follows a host-mode STALL, with bit 5 set;
- a latest-packet flush always raises the interrupt;
- the error bit and the stalled bit survive any cycle without a write;
- bit 7 is 0 in device mode.

Some behaviours need an ordered history and can only be shown by the bench's scenarios against its packet-queue model: the retry count reaching three, a NAK in between restarting it, the frame count hitting the NAK limit or being cleared by an acknowledge, abort-versus-flush, and the two-packet TX-ready sequence.

// File: rtl/tx_ep_ctrl.sv
module tx_ep_ctrl #(
  parameter int FIFO_PKTS = 2,
  parameter int NAK_W     = 8,
  parameter int MAX_TRIES = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             host_mode,
  input  logic [1:0]       ep_kind,
  input  logic             wr_en,
  input  logic [7:0]       wr_data,
  output logic [7:0]       rd_data,
  input  logic             ev_sent,
  input  logic             ev_noack,
  input  logic             ev_nak,
  input  logic             ev_stall,
  input  logic             ev_in,
  input  logic             sof_tick,
  input  logic [NAK_W-1:0] nak_limit,
  output logic             toggle_clr,
  output logic             send_setup,
  output logic             stall_reply,
  output logic             fifo_flush_last,
  output logic             fifo_flush_all,
  output logic             tx_irq,
  output logic             dma_abort,
  output logic             ep_halted
);
  localparam int CW = $clog2(FIFO_PKTS + 1);
  localparam int RW = $clog2(MAX_TRIES);

  logic [CW-1:0]    cnt, cnt_nx;
  logic [RW-1:0]    rty;
  logic [NAK_W-1:0] nak_cnt;
  logic             b4, stalled, err, nakto, nak_on;

  wire is_bulk  = ep_kind == 2'b10;
  wire retry_ep = ep_kind[1];
  wire empty    = cnt == '0;
  wire full     = cnt == CW'(FIFO_PKTS);
  wire w_flush  = wr_en & wr_data[3];
  wire w_rdy    = wr_en & wr_data[0];
  wire abort    = w_flush & w_rdy;
  wire drop     = w_flush & ~w_rdy & ~empty;
  wire commit   = w_rdy & ~w_flush & ~full;
  wire sent     = ev_sent & ~empty;
  wire err_set  = host_mode & retry_ep & ev_noack & (rty == RW'(MAX_TRIES - 1));
  wire kill     = err_set | ev_stall;
  wire underrun = ~host_mode & ev_in & empty & ~b4;
  wire hs       = ev_sent | ev_stall;
  wire nak_hit  = nak_on & sof_tick & (nak_limit != '0) &
                  (nak_cnt == nak_limit - NAK_W'(1));

  always_comb begin
    cnt_nx = cnt;
    if (sent) cnt_nx = cnt_nx - CW'(1);
    if (drop && cnt_nx != '0) cnt_nx = cnt_nx - CW'(1);
    if (commit) cnt_nx = cnt_nx + CW'(1);
    if (kill) cnt_nx = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0; rty <= '0; nak_cnt <= '0; nak_on <= 1'b0;
      b4 <= 1'b0; stalled <= 1'b0; err <= 1'b0; nakto <= 1'b0;
      toggle_clr <= 1'b0; fifo_flush_last <= 1'b0; fifo_flush_all <= 1'b0;
      tx_irq <= 1'b0; dma_abort <= 1'b0;
    end else begin
      cnt <= cnt_nx;
      if (wr_en) b4 <= wr_data[4];

      if (ev_stall) stalled <= 1'b1;
      else if (wr_en && !wr_data[5]) stalled <= 1'b0;

      if (err_set || underrun) err <= 1'b1;
      else if (wr_en && !wr_data[2]) err <= 1'b0;

      if (nak_hit) nakto <= 1'b1;
      else if (wr_en && !wr_data[7]) nakto <= 1'b0;

      if (hs || ev_nak || err_set) rty <= '0;
      else if (host_mode && retry_ep && ev_noack) rty <= rty + RW'(1);

      if (hs || nak_hit) begin
        nak_on <= 1'b0;
        nak_cnt <= '0;
      end else begin
        if (nak_on && sof_tick && nak_limit != '0) nak_cnt <= nak_cnt + NAK_W'(1);
        if (host_mode && is_bulk && ev_nak) nak_on <= 1'b1;
      end

      toggle_clr      <= wr_en & (wr_data[6] | (host_mode & wr_data[4]));
      fifo_flush_last <= drop | abort;
      fifo_flush_all  <= kill;
      tx_irq          <= sent | drop | abort | err_set;
      dma_abort       <= host_mode & ev_stall;
    end
  end

  assign send_setup  = host_mode & b4;
  assign stall_reply = ~host_mode & b4;
  assign ep_halted   = host_mode & nakto;
  assign rd_data     = {host_mode & nakto, 1'b0, stalled, b4, 1'b0, err, ~empty, full};
endmodule

// File: rtl/tx_ep_ctrl_chk.sv
module tx_ep_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       host_mode,
  input logic       wr_en,
  input logic [7:0] wr_data,
  input logic [7:0] rd_data,
  input logic       toggle_clr,
  input logic       fifo_flush_last,
  input logic       fifo_flush_all,
  input logic       tx_irq,
  input logic       dma_abort
);
  assert_toggle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && wr_data[6] |=> toggle_clr);

  assert_kill_empty_R8: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_flush_all |-> rd_data[1:0] == 2'b00);

  assert_dma_host_R9: assert property (@(posedge clk) disable iff (!rst_n)
    dma_abort |-> $past(host_mode) && rd_data[5]);

  assert_flush_irq_R5: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_flush_last |-> tx_irq);

  assert_sticky_err_R12: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[2] && !wr_en |=> rd_data[2]);

  assert_sticky_stall_R12: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[5] && !wr_en |=> rd_data[5]);

  assert_reserved_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !host_mode |-> !rd_data[7]);
endmodule

bind tx_ep_ctrl tx_ep_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .host_mode(host_mode), .wr_en(wr_en),
  .wr_data(wr_data), .rd_data(rd_data), .toggle_clr(toggle_clr),
  .fifo_flush_last(fifo_flush_last), .fifo_flush_all(fifo_flush_all),
  .tx_irq(tx_irq), .dma_abort(dma_abort)
);

// File: tb/test_tx_ep_ctrl.sv
`timescale 1ns/1ps
module test_tx_ep_ctrl;
  localparam int PKTS = 2;
  localparam int NW   = 8;

  logic clk = 0, rst_n = 0;
  logic host_mode = 1;
  logic [1:0] ep_kind = 2'b10;
  logic wr_en = 0;
  logic [7:0] wr_data = 0;
  logic ev_sent = 0, ev_noack = 0, ev_nak = 0, ev_stall = 0, ev_in = 0, sof_tick = 0;
  logic [NW-1:0] nak_limit = 0;
  logic [7:0] rd_data;
  logic toggle_clr, send_setup, stall_reply, fifo_flush_last, fifo_flush_all;
  logic tx_irq, dma_abort, ep_halted;

  always #2.5 clk = ~clk;

  tx_ep_ctrl #(.FIFO_PKTS(PKTS), .NAK_W(NW), .MAX_TRIES(3)) i_tx_ep_ctrl (
    .clk(clk), .rst_n(rst_n), .host_mode(host_mode), .ep_kind(ep_kind),
    .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .ev_sent(ev_sent), .ev_noack(ev_noack), .ev_nak(ev_nak), .ev_stall(ev_stall),
    .ev_in(ev_in), .sof_tick(sof_tick), .nak_limit(nak_limit),
    .toggle_clr(toggle_clr), .send_setup(send_setup), .stall_reply(stall_reply),
    .fifo_flush_last(fifo_flush_last), .fifo_flush_all(fifo_flush_all),
    .tx_irq(tx_irq), .dma_abort(dma_abort), .ep_halted(ep_halted)
  );

  int n_chk = 0, n_fail = 0;
  bit run = 0;

  function automatic void chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endfunction

  // reference model: packet queue plus sticky flags
  int q[$];
  int pid = 0, m_rty = 0, m_ncnt = 0;
  bit m_non, m_b4, m_stl, m_err, m_nto;
  bit e_tog, e_last, e_all, e_irq, e_dma;

  always @(posedge clk) begin
    if (!rst_n) begin
      q.delete(); m_rty = 0; m_ncnt = 0; m_non = 0; m_b4 = 0; m_stl = 0; m_err = 0; m_nto = 0;
      e_tog = 0; e_last = 0; e_all = 0; e_irq = 0; e_dma = 0;
    end else begin
      automatic int n = q.size();
      automatic bit empty = (n == 0);
      automatic bit flush = wr_en && wr_data[3];
      automatic bit rdy = wr_en && wr_data[0];
      automatic bit retry = ep_kind[1];
      automatic bit errnow = host_mode && retry && ev_noack && m_rty == 2;
      automatic bit kill = errnow || ev_stall;
      automatic bit und = !host_mode && ev_in && empty && !m_b4;
      automatic bit hit = m_non && sof_tick && nak_limit != 0 && m_ncnt + 1 == int'(nak_limit);
      e_tog  = wr_en && (wr_data[6] || (host_mode && wr_data[4]));
      e_last = flush && (rdy || !empty);
      e_irq  = (ev_sent && !empty) || e_last || errnow;
      e_all  = kill;
      e_dma  = host_mode && ev_stall;
      if (kill) q.delete();
      else begin
        if (ev_sent && q.size() > 0) void'(q.pop_front());
        if (flush && !rdy && q.size() > 0) void'(q.pop_back());
        if (rdy && !flush && n < PKTS) begin q.push_back(pid); pid++; end
      end
      m_stl = ev_stall ? 1'b1 : (wr_en && !wr_data[5]) ? 1'b0 : m_stl;
      m_err = (errnow || und) ? 1'b1 : (wr_en && !wr_data[2]) ? 1'b0 : m_err;
      m_nto = hit ? 1'b1 : (wr_en && !wr_data[7]) ? 1'b0 : m_nto;
      if (ev_sent || ev_stall || ev_nak || errnow) m_rty = 0;
      else if (host_mode && retry && ev_noack) m_rty++;
      if (ev_sent || ev_stall || hit) begin m_non = 0; m_ncnt = 0; end
      else begin
        if (m_non && sof_tick && nak_limit != 0) m_ncnt++;
        if (host_mode && ep_kind == 2'b10 && ev_nak) m_non = 1;
      end
      if (wr_en) m_b4 = wr_data[4];
    end
  end

  always @(negedge clk) begin
    if (rst_n && run) begin
      automatic int exp_rd = {(host_mode && m_nto), 1'b0, m_stl, m_b4, 1'b0, m_err,
                              (q.size() != 0), (q.size() == PKTS)};
      chk("R2 model rd_data", rd_data, exp_rd);
      chk("R7 model toggle_clr", toggle_clr, e_tog);
      chk("R5 model flush_last", fifo_flush_last, e_last);
      chk("R8 model flush_all", fifo_flush_all, e_all);
      chk("R4 model tx_irq", tx_irq, e_irq);
      chk("R9 model dma_abort", dma_abort, e_dma);
      chk("R10 model stall_reply", stall_reply, !host_mode && m_b4);
      chk("R7 model send_setup", send_setup, host_mode && m_b4);
      chk("R13 model ep_halted", ep_halted, host_mode && m_nto);
    end
  end

  task automatic cyc(); @(posedge clk); #1; endtask
  task automatic wr(input logic [7:0] d);
    wr_en = 1; wr_data = d; cyc(); wr_en = 0; wr_data = 0;
  endtask
  task automatic pulse(input int which);
    case (which)
      0: ev_sent = 1; 1: ev_noack = 1; 2: ev_nak = 1;
      3: ev_stall = 1; 4: ev_in = 1; default: sof_tick = 1;
    endcase
    cyc();
    ev_sent = 0; ev_noack = 0; ev_nak = 0; ev_stall = 0; ev_in = 0; sof_tick = 0;
  endtask

  task automatic finish_up();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    #1_000_000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: run did not complete");
    finish_up();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    chk("R1 reset rd_data", rd_data, 8'h00);
    chk("R1 reset strobes", {toggle_clr, send_setup, stall_reply, fifo_flush_last,
        fifo_flush_all, tx_irq, dma_abort, ep_halted}, 0);
    run = 1;
    cyc();

    // host bulk: commits and double buffering
    wr(8'h01); chk("R3 first commit", rd_data, 8'h02);
    wr(8'h01); chk("R3 second commit full", rd_data, 8'h03);
    wr(8'h01); chk("R3 commit when full ignored", rd_data, 8'h03);
    wr(8'h02); chk("R2 bit1 write ignored", rd_data, 8'h03);
    pulse(0);  chk("R4 sent irq", tx_irq, 1); chk("R4 sent count", rd_data, 8'h02);
    wr(8'h08); chk("R5 flush strobe", {fifo_flush_last, tx_irq}, 2'b11);
    chk("R5 flush empties", rd_data, 8'h00);
    wr(8'h08); chk("R5 flush on empty ignored", {fifo_flush_last, tx_irq, rd_data}, 0);
    wr(8'h01); wr(8'h09);
    chk("R6 abort strobe", {fifo_flush_last, tx_irq}, 2'b11);
    chk("R6 abort keeps count", rd_data, 8'h02);

    // toggle clear and setup
    wr(8'h40); chk("R7 clear toggle", toggle_clr, 1);
    wr(8'h11); chk("R7 setup clears toggle", {toggle_clr, send_setup}, 2'b11);
    chk("R7 setup read", rd_data, 8'h13);
    wr(8'h00); chk("R7 setup dropped", send_setup, 0);

    // retries
    pulse(1); pulse(1); chk("R8 two misses no error", rd_data[2], 0);
    pulse(1); chk("R8 third miss error", rd_data, 8'h04);
    chk("R8 error strobes", {fifo_flush_all, tx_irq}, 2'b11);
    wr(8'h04); chk("R12 write 1 keeps error", rd_data[2], 1);
    wr(8'h00); chk("R12 write 0 clears error", rd_data[2], 0);
    pulse(1); pulse(1); pulse(2); pulse(1);
    chk("R8 NAK restarts count", rd_data[2], 0);
    ep_kind = 2'b00;
    pulse(1); pulse(1); pulse(1); chk("R8 control ep ignores misses", rd_data[2], 0);
    ep_kind = 2'b11;
    pulse(1); pulse(1); chk("R8 interrupt ep counts", rd_data[2], 1);
    wr(8'h00);
    ep_kind = 2'b10;

    // host stall
    wr(8'h01); pulse(3);
    chk("R9 stall read", rd_data, 8'h20);
    chk("R9 stall strobes", {fifo_flush_all, dma_abort}, 2'b11);
    wr(8'h20); chk("R12 write 1 keeps stalled", rd_data[5], 1);
    wr(8'h00); chk("R12 write 0 clears stalled", rd_data[5], 0);

    // NAK timer
    nak_limit = 3;
    wr(8'h01); pulse(2); pulse(5); pulse(5);
    chk("R13 before limit", {rd_data[7], ep_halted}, 2'b00);
    pulse(5); chk("R13 limit reached", {rd_data[7], ep_halted}, 2'b11);
    wr(8'h80); chk("R12 write 1 keeps timeout", rd_data[7], 1);
    wr(8'h00); chk("R13 timeout cleared", ep_halted, 0);
    pulse(2); pulse(5); pulse(5); pulse(0); pulse(5); pulse(5); pulse(5);
    chk("R13 ack resets timer", rd_data[7], 0);
    nak_limit = 0;
    pulse(2); for (int i = 0; i < 6; i++) pulse(5);
    chk("R13 limit zero disabled", rd_data[7], 0);

    // device mode
    host_mode = 0;
    wr(8'h80); chk("R2 device bit7 reads 0", rd_data[7], 0);
    wr(8'h10); chk("R10 stall reply", stall_reply, 1);
    pulse(4); chk("R11 no underrun while stalling", rd_data[2], 0);
    wr(8'h11); pulse(3);
    chk("R10 stall sent", rd_data[5:0], 6'h30);
    chk("R10 device stall strobes", {fifo_flush_all, dma_abort}, 2'b10);
    wr(8'h00); pulse(4); chk("R11 underrun", rd_data, 8'h04);
    wr(8'h00);
    wr(8'h01); pulse(4); chk("R11 no underrun with data", rd_data[2], 0);
    cyc(); cyc();
    finish_up();
  end
endmodule